// File: doc/BRIEF.md
# Half-Precision Operand Swizzle and Narrowing Stage

This stage takes one 32-bit source word and turns it into a pair of binary16 operands for a two-lane half-precision datapath. A 2-bit select sets how the word is read. It can keep the two packed halves as they are. It can copy the low half or the high half into both lanes. It can also treat the whole word as a binary32 value, narrow it to binary16 and copy the result into both lanes.

After the lane selection, two sign controls act on both lanes in a fixed order. The absolute-value control acts first and the negate control acts second. The result goes into a register, so the lanes and a valid flag appear one clock after a valid input. When no valid input arrives, the output lanes keep their last values.

Narrowing always truncates toward zero. Any result that would be subnormal in binary16 becomes a zero with the same sign. The multiplier's own flush setting has no effect on this.

Top module: `half_operand_prep`

## Requirements
- R1: While `rstN` is low, and until the first valid input has been registered, `outValid` is 0 and both lanes are 0x0000.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and the lanes shown in that cycle come from that input.
- R3: Select 0 (pair) gives lane1 = src[31:16] and lane0 = src[15:0].
- R4: Select 2 (low copy) gives both lanes src[15:0].
- R5: Select 3 (high copy) gives both lanes src[31:16].
- R6: Select 1 (narrow) reads src as binary32 with sign bit 31, exponent bits 30:23 and fraction bits 22:0, and puts the same binary16 value in both lanes. For a biased exponent e from 113 to 142, the result is sign, exponent e-112 and fraction src[22:13], which is truncation toward zero.
- R7: When narrowing a value with e of 112 or below, which covers binary32 zeros and subnormals, the result is a zero with the input's sign (0x0000 or 0x8000).
- R8: When narrowing a finite value with e from 143 to 254, the result is the largest finite binary16 with the input's sign (0x7BFF or 0xFBFF), not infinity.
- R9: When narrowing, infinity gives 0x7C00 with the input's sign, and any NaN gives the quiet NaN 0x7E00 with the input's sign.
- R10: The absolute-value control clears bit 15 of each lane. After that, the negate control inverts bit 15 of each lane. Bits 14:0 do not change, and this holds for NaN and infinity patterns too.
- R11: A cycle with `inValid` low gives `outValid` low in the next cycle and leaves both lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Source word and controls are valid this cycle |
| src | input | 32 | Source register word |
| swzSel | input | 2 | 0 pair, 1 narrow binary32, 2 low copy, 3 high copy |
| absEn | input | 1 | Clear the sign of both lanes |
| negEn | input | 1 | Invert the sign of both lanes, after abs |
| outValid | output | 1 | Lanes hold a new result |
| lane1 | output | 16 | Upper binary16 operand |
| lane0 | output | 16 | Lower binary16 operand |

## Verification
The assertions assume that `inValid` and the other inputs are driven to known values from the first clock edge, and that `swzSel` only matters in cycles when `inValid` is high. The bench keeps every input at 0 during reset and changes inputs only between clock edges. Its narrowing stimulus includes the exponent edges 112/113 and 142/143, both infinities, NaNs of both signs, and a binary32 value that would round up to infinity under round-to-nearest. Idle gaps sit between bursts so the hold behaviour is observed.

// File: rtl/hprep_pkg.sv
package hprep_pkg;
  localparam int SRC_W      = 32;
  localparam int HALF_W     = 16;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int HP_EXP_W   = 5;
  localparam int HP_FRAC_W  = 10;
  localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
  localparam int HP_BIAS    = (1 << (HP_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF  = SP_BIAS - HP_BIAS;
  localparam int HP_EXP_MAX = (1 << HP_EXP_W) - 2;
  localparam int FRAC_DROP  = SP_FRAC_W - HP_FRAC_W;

  typedef enum logic [1:0] {
    SWZ_PAIR   = 2'd0,
    SWZ_NARROW = 2'd1,
    SWZ_LOW    = 2'd2,
    SWZ_HIGH   = 2'd3
  } swz_e;

  typedef struct packed {
    logic load;
    logic useNarrow;
    logic lowToLane1;
    logic highToLane0;
    logic clearSign;
    logic flipSign;
  } strobe_t;
endpackage

// File: rtl/hprep_narrow.sv
module hprep_narrow
  import hprep_pkg::*;
(
  input  logic [SRC_W-1:0]  wordIn,
  output logic [HALF_W-1:0] halfOut
);
  localparam logic [SP_EXP_W-1:0] EXP_ALL1  = '1;
  localparam logic [SP_EXP_W-1:0] EXP_LOW   = SP_EXP_W'(BIAS_DIFF);
  localparam logic [SP_EXP_W-1:0] EXP_HIGH  = SP_EXP_W'(BIAS_DIFF + HP_EXP_MAX);
  localparam logic [HALF_W-2:0]   MAX_FIN   = {{(HP_EXP_W-1){1'b1}}, 1'b0, {HP_FRAC_W{1'b1}}};
  localparam logic [HALF_W-2:0]   INF_MAG   = {{HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
  localparam logic [HALF_W-2:0]   QNAN_MAG  = {{HP_EXP_W{1'b1}}, 1'b1, {(HP_FRAC_W-1){1'b0}}};

  logic                 signBit;
  logic [SP_EXP_W-1:0]  expField;
  logic [SP_FRAC_W-1:0] fracField;
  logic [SP_EXP_W-1:0]  rebiased;
  logic [HALF_W-2:0]    magOut;

  assign signBit   = wordIn[SRC_W-1];
  assign expField  = wordIn[SRC_W-2 -: SP_EXP_W];
  assign fracField = wordIn[SP_FRAC_W-1:0];
  assign rebiased  = expField - EXP_LOW;

  always_comb begin
    if (expField == EXP_ALL1) begin
      magOut = (fracField != '0) ? QNAN_MAG : INF_MAG;
    end else if (expField > EXP_HIGH) begin
      magOut = MAX_FIN;
    end else if (expField <= EXP_LOW) begin
      magOut = '0;
    end else begin
      magOut = {rebiased[HP_EXP_W-1:0], fracField[SP_FRAC_W-1 -: HP_FRAC_W]};
    end
  end

  assign halfOut = {signBit, magOut};
endmodule

// File: rtl/hprep_ctrl.sv
module hprep_ctrl
  import hprep_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic [1:0] swzSel,
  input  logic    absEn,
  input  logic    negEn,
  output strobe_t stb,
  output logic    outValid
);
  swz_e swzMode;
  assign swzMode = swz_e'(swzSel);

  always_comb begin
    stb             = '0;
    stb.load        = inValid;
    stb.clearSign   = absEn;
    stb.flipSign    = negEn;
    unique case (swzMode)
      SWZ_PAIR:   ;
      SWZ_NARROW: stb.useNarrow   = 1'b1;
      SWZ_LOW:    stb.lowToLane1  = 1'b1;
      SWZ_HIGH:   stb.highToLane0 = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: the output flag trails the input flag by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R11: no input gives no output
  a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/hprep_dp.sv
module hprep_dp
  import hprep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SRC_W-1:0]  src,
  output logic [HALF_W-1:0] lane1Q,
  output logic [HALF_W-1:0] lane0Q
);
  localparam int SIGN_POS = HALF_W - 1;

  logic [HALF_W-1:0] halfHi, halfLo, narrowed;
  logic [HALF_W-1:0] pick1, pick0, fin1, fin0;

  assign halfHi = src[SRC_W-1 -: HALF_W];
  assign halfLo = src[HALF_W-1:0];

  hprep_narrow u_narrow (
    .wordIn (src),
    .halfOut(narrowed)
  );

  always_comb begin
    if (stb.useNarrow) begin
      pick1 = narrowed;
      pick0 = narrowed;
    end else begin
      pick1 = stb.lowToLane1  ? halfLo : halfHi;
      pick0 = stb.highToLane0 ? halfHi : halfLo;
    end
  end

  function automatic logic [HALF_W-1:0] signMod(input logic [HALF_W-1:0] v,
                                                input logic clr, input logic flip);
    logic s;
    s = (v[SIGN_POS] & ~clr) ^ flip;
    return {s, v[SIGN_POS-1:0]};
  endfunction

  assign fin1 = signMod(pick1, stb.clearSign, stb.flipSign);
  assign fin0 = signMod(pick0, stb.clearSign, stb.flipSign);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lane1Q <= '0;
      lane0Q <= '0;
    end else if (stb.load) begin
      lane1Q <= fin1;
      lane0Q <= fin0;
    end
  end

  // R11: lanes hold when nothing is loaded
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(lane1Q) && $stable(lane0Q)));
  // R6: a narrowed result is the same in both lanes
  a_r6_lanes_match: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.useNarrow) |=> (lane1Q == lane0Q));
  // R10: absolute value without negate leaves both signs clear
  a_r10_abs_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.clearSign && !stb.flipSign) |=> (!lane1Q[SIGN_POS] && !lane0Q[SIGN_POS]));
  // R3: pair mode keeps the magnitude bits of each half
  a_r3_pair_mag: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.useNarrow && !stb.lowToLane1 && !stb.highToLane0) |=>
      (lane1Q[SIGN_POS-1:0] == $past(src[SRC_W-2 -: HALF_W-1]) &&
       lane0Q[SIGN_POS-1:0] == $past(src[SIGN_POS-1:0])));
  // R8: narrowing never yields an infinity from a finite input
  a_r8_no_inf_from_finite: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.useNarrow && src[SRC_W-2 -: SP_EXP_W] != '1) |=>
      (lane0Q[SIGN_POS-1 -: HP_EXP_W] != '1));
endmodule

// File: rtl/half_operand_prep.sv
module half_operand_prep
  import hprep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] src,
  input  logic [1:0]  swzSel,
  input  logic        absEn,
  input  logic        negEn,
  output logic        outValid,
  output logic [15:0] lane1,
  output logic [15:0] lane0
);
  strobe_t stb;

  hprep_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .swzSel  (swzSel),
    .absEn   (absEn),
    .negEn   (negEn),
    .stb     (stb),
    .outValid(outValid)
  );

  hprep_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .src   (src),
    .lane1Q(lane1),
    .lane0Q(lane0)
  );
endmodule

// File: tb/half_operand_prep_bench.sv
`timescale 1ns/1ps
module half_operand_prep_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] src = '0;
  logic [1:0]  swzSel = '0;
  logic        absEn = 1'b0;
  logic        negEn = 1'b0;
  logic        outValid;
  logic [15:0] lane1, lane0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastOut = '0;
  bit          monOn = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  half_operand_prep u_half_operand_prep (
    .clk(clk), .rstN(rstN), .inValid(inValid), .src(src), .swzSel(swzSel),
    .absEn(absEn), .negEn(negEn), .outValid(outValid), .lane1(lane1), .lane0(lane0)
  );

  function automatic logic [15:0] refNarrow(input logic [31:0] w);
    int e;
    e = int'(w[30:23]);
    if (e == 255) return (w[22:0] != 0) ? {w[31], 15'h7E00} : {w[31], 15'h7C00};
    if (e >= 143) return {w[31], 15'h7BFF};
    if (e <= 112) return {w[31], 15'h0000};
    return {w[31], 5'(e - 112), w[22:13]};
  endfunction

  function automatic logic [15:0] refSign(input logic [15:0] v, input bit a, input bit n);
    logic [15:0] r;
    r = v;
    if (a) r[15] = 1'b0;
    if (n) r[15] = ~r[15];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [1:0] sel, input bit a, input bit n, input string tag);
    logic [15:0] e1, e0;
    @(negedge clk);
    inValid = 1'b1; src = w; swzSel = sel; absEn = a; negEn = n;
    case (sel)
      2'd0: begin e1 = w[31:16]; e0 = w[15:0]; end
      2'd1: begin e1 = refNarrow(w); e0 = e1; end
      2'd2: begin e1 = w[15:0]; e0 = w[15:0]; end
      default: begin e1 = w[31:16]; e0 = w[31:16]; end
    endcase
    expQ.push_back({refSign(e1, a, n), refSign(e0, a, n)});
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; src = $urandom; swzSel = 2'($urandom); absEn = 1'b1; negEn = 1'b1;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (monOn) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2 unexpected valid", {lane1, lane0}, 32'h0);
          end else begin
            logic [31:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check({lane1, lane0} === e, t, {lane1, lane0}, e);
            lastOut = e;
          end
        end else begin
          check(expQ.size() == 0, "R2 missing valid", 32'h0, 32'h1);
          check({lane1, lane0} === lastOut, "R11 hold", {lane1, lane0}, lastOut);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(outValid === 1'b0 && lane1 === 16'h0 && lane0 === 16'h0, "R1 reset state",
          {15'h0, outValid, lane1}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    idle(2);
    // R3 pair
    drive(32'hBC00_3C00, 2'd0, 0, 0, "R3 pair");
    drive(32'h7E00_8001, 2'd0, 0, 0, "R3 pair nan/sub");
    // R4 low copy, R5 high copy
    drive(32'h1234_C567, 2'd2, 0, 0, "R4 low copy");
    drive(32'h1234_C567, 2'd3, 0, 0, "R5 high copy");
    idle(3);
    // R6 in-range narrowing
    drive(32'h3F80_0000, 2'd1, 0, 0, "R6 narrow 1.0");
    drive(32'hC049_0FDB, 2'd1, 0, 0, "R6 narrow -pi truncate");
    drive(32'h3880_0000, 2'd1, 0, 0, "R6 smallest normal e113");
    drive(32'h477F_F000, 2'd1, 0, 0, "R6 e142 no round up");
    drive(32'h477F_FFFF, 2'd1, 0, 0, "R6 e142 truncate to max");
    // R7 underflow
    drive(32'h387F_FFFF, 2'd1, 0, 0, "R7 e112 flush");
    drive(32'hB87F_FFFF, 2'd1, 0, 0, "R7 negative flush");
    drive(32'h0000_0001, 2'd1, 0, 0, "R7 sp subnormal");
    drive(32'h8000_0000, 2'd1, 0, 0, "R7 negative zero");
    idle(1);
    // R8 overflow saturates to max finite
    drive(32'h4780_0000, 2'd1, 0, 0, "R8 e143");
    drive(32'h7F7F_FFFF, 2'd1, 0, 0, "R8 largest sp");
    drive(32'hD015_02F9, 2'd1, 0, 0, "R8 negative large");
    // R9 specials
    drive(32'h7F80_0000, 2'd1, 0, 0, "R9 +inf");
    drive(32'hFF80_0000, 2'd1, 0, 0, "R9 -inf");
    drive(32'h7FC0_0001, 2'd1, 0, 0, "R9 +nan");
    drive(32'hFF80_0001, 2'd1, 0, 0, "R9 -nan signalling");
    idle(2);
    // R10 sign controls
    drive(32'hBC00_3C00, 2'd0, 1, 0, "R10 abs pair");
    drive(32'hBC00_3C00, 2'd0, 0, 1, "R10 neg pair");
    drive(32'hBC00_3C00, 2'd0, 1, 1, "R10 abs then neg");
    drive(32'hFE00_7E00, 2'd0, 1, 0, "R10 abs nan");
    drive(32'h7F80_0000, 2'd1, 0, 1, "R10 neg narrowed inf");
    drive(32'hC049_0FDB, 2'd1, 1, 1, "R10 abs neg narrowed");
    drive(32'h8123_4567, 2'd2, 0, 1, "R10 neg low copy");
    drive(32'h8123_4567, 2'd3, 1, 0, "R10 abs high copy");
    idle(4);
    for (int i = 0; i < 40; i++) begin
      drive($urandom, 2'($urandom), bit'($urandom), bit'($urandom), "R3 R4 R5 R6 R10 mixed");
      if (i % 7 == 3) idle(1);
    end
    idle(4);
    done = 1'b1;
    check(expQ.size() == 0, "R2 drained", 32'(expQ.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule